// File: doc/BRIEF.md
# Inbound Doorbell Queue Pointer Controller

This block keeps the pointers and status for a ring of inbound doorbell messages that live in memory. A write pointer advances by one entry each time an arrival strobe is accepted. A read pointer is loaded by software, and software moves it forward in one of two ways: by setting a one-shot increment bit, which moves it one entry, or by writing a new value directly, which retires several entries at once. Each entry is 8 bytes. Both pointers advance only within an index field of `QUEUE_LOG2` bits starting at byte-address bit 3. When that field wraps, the pointer returns to the ring base and the upper address bits are left unchanged.

The block reports an empty flag. This flag is also forced high while the controller-enable input is low. A sticky pending flag is set while the ring holds work and the interrupt enable is on. The interrupt output drives that flag out, gated by the enable bit and by the controller enable. If an arrival would fill the last free slot, it is refused and a sticky overflow flag is set.

Software reaches all of this through a small register port with a two-bit address. Reads are combinational. Writes take effect at the clock edge.

Top module: `doorbell_queue_ctrl`

## Requirements
- R1: After reset, both pointers are 0, the control register reads 0 and the status register reads 2 (empty set, pending and overflow clear).
- R2: A write to address 2 loads the read pointer from bits 31..3 of the write data. Bits 2..0 of the pointer always read 0.
- R3: Writing address 0 with bit 0 set makes bit 0 read 1 in the next cycle. At the edge after that, the read pointer advances one entry and bit 0 returns to 0. Bit 1 of address 0 is the interrupt enable.
- R4: Address 3 holds the write pointer, with the same write and alignment rule as R2. An accepted arrival strobe advances it by 8 bytes.
- R5: A pointer advance changes only the index field (bits 3+QUEUE_LOG2-1..3). This field wraps from its last value to 0 and the bits above it are kept.
- R6: Status bit 1 (empty) reads 1 when the two pointers are equal or when ctrl_en_i is low, and reads 0 otherwise.
- R7: An arrival with ctrl_en_i high is refused when advancing the write pointer would make it equal to the read pointer. A refused arrival sets status bit 2 (overflow). That bit stays set until a status write has bit 2 set.
- R8: When an arrival and a pending increment meet at one edge, both pointers move. The full test uses the read pointer as it was before that edge.
- R9: Status bit 0 (pending) is set at any edge where ctrl_en_i, the interrupt enable and a non-empty ring are all present. Otherwise a status write with bit 0 set clears it, and a write with bit 0 clear leaves it unchanged.
- R10: irq_o is high exactly when the pending bit, the interrupt enable and ctrl_en_i are all high.
- R11: Arrival strobes while ctrl_en_i is low leave the write pointer and the overflow bit unchanged.
- R12: A direct write to the read pointer takes priority over an increment that is pending at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_en_i | input | 1 | Controller enable |
| db_arrive_i | input | 1 | One-cycle doorbell arrival strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 status, 2 read pointer, 3 write pointer |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Doorbell pending interrupt |

## Verification
A wrong pointer value appears on the next read of address 2 or 3. Because the empty flag compares the pointers, the same fault also shows on status bit 1 and on irq_o within one to two cycles. A wrong full test shows up after a ring has been filled: either the write pointer catches the read pointer and reads as empty, or the overflow bit is set when it should not be. A bad one-shot increment shows in the control readback, which must read 1 for exactly one cycle, and in the one-entry step of address 2 at the following edge.

// File: rtl/db_queue_pkg.sv
package db_queue_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_RPTR = 2'd2,
    REG_WPTR = 2'd3
  } reg_sel_e;

  localparam int unsigned CT_STEP  = 0;
  localparam int unsigned CT_IE    = 1;
  localparam int unsigned ST_PEND  = 0;
  localparam int unsigned ST_EMPTY = 1;
  localparam int unsigned ST_OVF   = 2;
  localparam int unsigned ENTRY_SHIFT = 3;  // 8-byte entries
endpackage

// File: rtl/db_ring_ptr.sv
module db_ring_ptr #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OFS_W      = 3,
  parameter int unsigned QUEUE_LOG2 = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:OFS_W] wdata_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [ADDR_W-1:0] ptr_inc_o
);
  localparam int unsigned IDX_LO = OFS_W;
  localparam int unsigned IDX_HI = OFS_W + QUEUE_LOG2 - 1;

  logic [ADDR_W-1:0]     ptr_q;
  logic [QUEUE_LOG2-1:0] idx_nxt;

  assign idx_nxt = ptr_q[IDX_HI:IDX_LO] + 1'b1;

  always_comb begin
    ptr_inc_o = ptr_q;
    ptr_inc_o[IDX_HI:IDX_LO] = idx_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (wr_i)  ptr_q <= {wdata_i, {OFS_W{1'b0}}};
    else if (inc_i) ptr_q <= ptr_inc_o;
  end

  assign ptr_o = ptr_q;

  p_ptr_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q[OFS_W-1:0] == '0);

  p_step_one_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !wr_i |=> ptr_q[IDX_HI:IDX_LO] == $past(ptr_q[IDX_HI:IDX_LO]) + 1'b1);

  generate
    if (IDX_HI < ADDR_W - 1) begin : g_base_chk
      p_base_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(ptr_q[ADDR_W-1:IDX_HI+1]));
    end
  endgenerate
endmodule

// File: rtl/db_sticky_flags.sv
module db_sticky_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (set_i[i])  flag_q <= 1'b1;  // set beats clear
      else if (clr_i[i])  flag_q <= 1'b0;
    end
    assign flag_o[i] = flag_q;

    p_flag_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q && !clr_i[i] |=> flag_q);
  end
endmodule

// File: rtl/doorbell_queue_ctrl.sv
module doorbell_queue_ctrl
  import db_queue_pkg::*;
#(
  parameter int unsigned QUEUE_LOG2 = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_en_i,
  input  logic        db_arrive_i,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NFLAG  = 2;
  localparam int unsigned F_PEND = 0;
  localparam int unsigned F_OVF  = 1;

  logic wr_ctrl, wr_stat, wr_rptr, wr_wptr;
  logic step_q, ie_q;
  logic [DATA_W-1:0] rptr, rptr_inc, wptr, wptr_inc;
  logic ring_empty, ring_full, accept, refuse;
  logic [NFLAG-1:0] flag_set, flag_clr, flags;

  assign wr_ctrl = reg_wr_i && (reg_addr_i == REG_CTRL);
  assign wr_stat = reg_wr_i && (reg_addr_i == REG_STAT);
  assign wr_rptr = reg_wr_i && (reg_addr_i == REG_RPTR);
  assign wr_wptr = reg_wr_i && (reg_addr_i == REG_WPTR);

  // One-shot step: visible for one cycle, consumed at the next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      step_q <= wr_ctrl && reg_wdata_i[CT_STEP];
      if (wr_ctrl) ie_q <= reg_wdata_i[CT_IE];
    end
  end

  db_ring_ptr #(.ADDR_W(DATA_W), .OFS_W(ENTRY_SHIFT), .QUEUE_LOG2(QUEUE_LOG2)) u_rptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_rptr),
    .wdata_i   (reg_wdata_i[DATA_W-1:ENTRY_SHIFT]),
    .inc_i     (step_q),
    .ptr_o     (rptr),
    .ptr_inc_o (rptr_inc)
  );

  db_ring_ptr #(.ADDR_W(DATA_W), .OFS_W(ENTRY_SHIFT), .QUEUE_LOG2(QUEUE_LOG2)) u_wptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_wptr),
    .wdata_i   (reg_wdata_i[DATA_W-1:ENTRY_SHIFT]),
    .inc_i     (accept),
    .ptr_o     (wptr),
    .ptr_inc_o (wptr_inc)
  );

  assign ring_empty = (wptr == rptr);
  assign ring_full  = (wptr_inc == rptr);
  assign accept     = db_arrive_i && ctrl_en_i && !ring_full;
  assign refuse     = db_arrive_i && ctrl_en_i && ring_full;

  assign flag_set[F_PEND] = ctrl_en_i && ie_q && !ring_empty;
  assign flag_set[F_OVF]  = refuse;
  assign flag_clr[F_PEND] = wr_stat && reg_wdata_i[ST_PEND];
  assign flag_clr[F_OVF]  = wr_stat && reg_wdata_i[ST_OVF];

  db_sticky_flags #(.N(NFLAG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flags)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_e'(reg_addr_i))
      REG_CTRL: begin
        reg_rdata_o[CT_STEP] = step_q;
        reg_rdata_o[CT_IE]   = ie_q;
      end
      REG_STAT: begin
        reg_rdata_o[ST_PEND]  = flags[F_PEND];
        reg_rdata_o[ST_EMPTY] = ring_empty || !ctrl_en_i;
        reg_rdata_o[ST_OVF]   = flags[F_OVF];
      end
      REG_RPTR: reg_rdata_o = rptr;
      REG_WPTR: reg_rdata_o = wptr;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = flags[F_PEND] && ie_q && ctrl_en_i;

  p_step_self_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q && !(wr_ctrl && reg_wdata_i[CT_STEP]) |=> !step_q);

  p_refused_no_move_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse && !wr_wptr |=> $stable(wptr));

  p_refuse_sets_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse |=> flags[F_OVF]);

  p_pending_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_en_i && ie_q && !ring_empty |=> flags[F_PEND]);

  p_disabled_wptr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_en_i && !wr_wptr |=> $stable(wptr));

  p_write_beats_step_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rptr |=> rptr[DATA_W-1:ENTRY_SHIFT] == $past(reg_wdata_i[DATA_W-1:ENTRY_SHIFT]));
endmodule

// File: tb/doorbell_queue_ctrl_tb.sv
module doorbell_queue_ctrl_tb;
  localparam int QL = 4;
  localparam logic [31:0] SPAN = 32'(8 << QL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, arr = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] m_rp, m_wp;
  logic m_ie, m_step, m_pend, m_ovf;

  always #4 clk = ~clk;

  doorbell_queue_ctrl #(.QUEUE_LOG2(QL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_en_i(en), .db_arrive_i(arr),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] adv(logic [31:0] p);
    return (p & ~(SPAN - 1)) | ((p + 32'd8) & (SPAN - 1));
  endfunction

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {30'd0, m_ie, m_step};
      2'd1: return {29'd0, m_ovf, (m_wp == m_rp) || !en, m_pend};
      2'd2: return m_rp;
      default: return m_wp;
    endcase
  endfunction

  function automatic string tag_of(logic [1:0] a);
    case (a)
      2'd0: return "R3";
      2'd1: return "R6";
      2'd2: return "R2";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic full, wc, ws;
    full = (adv(m_wp) == m_rp);
    wc = wr && addr == 2'd0;
    ws = wr && addr == 2'd1;
    if (en && m_ie && m_wp != m_rp) m_pend = 1'b1;
    else if (ws && wdata[0])        m_pend = 1'b0;
    if (arr && en && full)          m_ovf = 1'b1;
    else if (ws && wdata[2])        m_ovf = 1'b0;
    if (wr && addr == 2'd2)  m_rp = wdata & ~32'd7;
    else if (m_step)         m_rp = adv(m_rp);
    if (wr && addr == 2'd3)  m_wp = wdata & ~32'd7;
    else if (arr && en && !full) m_wp = adv(m_wp);
    if (wc) m_ie = wdata[1];
    m_step = wc && wdata[0];
  endtask

  // compare every cycle, then advance model with the held inputs
  task automatic tick();
    #1;
    chk(tag_of(addr), rdata, m_read(addr));
    chk("R10", {31'd0, irq}, {31'd0, m_pend && m_ie && en});
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr = 1'b0; arr = 1'b0;
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d; tick();
  endtask

  task automatic strobe();
    arr = 1'b1; tick();
  endtask

  task automatic peek(logic [1:0] a, logic [31:0] exp, string tag);
    addr = a; #1;
    chk(tag, rdata, exp);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_rp = '0; m_wp = '0; m_ie = 0; m_step = 0; m_pend = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    peek(2'd1, 32'h2, "R1");
    peek(2'd2, 32'h0, "R1");
    peek(2'd3, 32'h0, "R1");
    peek(2'd0, 32'h0, "R1");
    // R2 alignment on direct write
    wreg(2'd2, 32'h1007);
    peek(2'd2, 32'h1000, "R2");
    wreg(2'd3, 32'h1005);
    en = 1'b1;
    peek(2'd1, 32'h2, "R6");
    // R4 arrival advances write pointer
    strobe();
    peek(2'd3, 32'h1008, "R4");
    peek(2'd1, 32'h0, "R6");
    // R9/R10 pending and interrupt
    wreg(2'd0, 32'h2);
    tick();
    peek(2'd1, 32'h1, "R9");
    chk("R10", {31'd0, irq}, 32'd1);
    // R3 one-shot step
    wreg(2'd0, 32'h3);
    peek(2'd0, 32'h3, "R3");
    peek(2'd2, 32'h1008, "R3");
    peek(2'd0, 32'h2, "R3");
    wreg(2'd1, 32'h1);
    peek(2'd1, 32'h2, "R9");
    // R5/R7 fill to full, wrap, refuse one
    for (int i = 0; i < 16; i++) strobe();
    peek(2'd3, 32'h1000, "R5");
    peek(2'd1, 32'h5, "R7");
    wreg(2'd1, 32'h0);
    peek(2'd1, 32'h5, "R9");
    // R8 arrival with pending step while full: refused against old read pointer
    wreg(2'd0, 32'h3);
    strobe();
    peek(2'd3, 32'h1000, "R8");
    peek(2'd2, 32'h1010, "R8");
    wreg(2'd0, 32'h3);
    strobe();
    peek(2'd3, 32'h1008, "R8");
    peek(2'd2, 32'h1018, "R8");
    // R6/R10/R11 disabled controller
    en = 1'b0;
    peek(2'd1, 32'h7, "R6");
    chk("R10", {31'd0, irq}, 32'd0);
    strobe();
    peek(2'd3, 32'h1008, "R11");
    wreg(2'd1, 32'h5);
    peek(2'd1, 32'h2, "R7");
    // R12 direct write beats pending step
    wreg(2'd0, 32'h1);
    wreg(2'd2, 32'h2000);
    peek(2'd2, 32'h2000, "R12");
    wreg(2'd3, 32'h2000);
    // mixed traffic against the reference model
    for (int c = 0; c < 4000; c++) begin
      logic [1:0] a;
      en  = ($urandom % 16) != 0;
      arr = ($urandom % 3) == 0;
      wr  = ($urandom % 5) == 0;
      a   = 2'($urandom % 4);
      addr = a;
      if (a[1]) wdata = 32'h2000 | ((($urandom % 16)) << 3) | ($urandom % 8);
      else      wdata = $urandom;
      tick();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule